// File: doc/BRIEF.md
# Synchronous Byte-Write SRAM Core

A single-port synchronous static memory whose word is made of several bytes. Address, write data and every control input except the output enable are sampled on the rising clock edge. A write either replaces the whole word (global write) or only the bytes picked by a per-byte select mask when the byte-write enable is high. Any selected cycle that is not a write is a read. Burst addresses are generated outside the core; the core accepts a new address on every cycle.

Reads take one of two run-time paths. In flow-through mode the output register is bypassed and data follows the captured address directly. In pipelined mode data passes through a rising-edge output register. Turn-off is single-cycle-deselect: a deselect, or a sleep cycle, takes effect on the outputs at the very edge that captures it, without waiting for the output register. The outputs of a tristate bus are modelled as a data-valid flag and a data word that reads zero when invalid. An asynchronous output enable gates both. A sleep input idles the core and keeps the stored contents.

Top module: `sync_bw_sram`

## Requirements
- R1: With `gw_i` high in a selected, awake cycle, every byte of the addressed word is written from `wdata_i`, whatever `bwe_i` and `bsel_i` are.
- R2: With `gw_i` low and `bwe_i` high, only the bytes whose `bsel_i` bit is 1 are written (bit k covers `wdata_i[8k+7:8k]`). With both `gw_i` and `bwe_i` low, nothing is written and the cycle is a read.
- R3: With `pipe_i` = 0 (flow-through), a read captured at edge E drives its word with `rvalid_o` = 1 from edge E until the next edge.
- R4: With `pipe_i` = 1 (pipelined), a read captured at edge E drives its word from edge E+1 until E+2. Back-to-back reads give one word per cycle after the first, so a four-beat burst takes 3-1-1-1 cycles here and 2-1-1-1 in flow-through.
- R5: A deselect (`sel_i` = 0) captured at an edge drops `rvalid_o` right after that edge in both modes. This includes the pipelined beat of a read captured one cycle earlier.
- R6: `oe_i` acts without the clock. While it is 0, `rvalid_o` is 0 and `rdata_o` is zero. Raising it again restores the current beat within the same cycle.
- R7: A cycle with `sleep_i` high writes nothing and yields no valid data after its edge. Stored contents are kept. A read in the first cycle with `sleep_i` low is served normally.
- R8: A read of an address in the cycle right after a write to it returns the newly written bytes.
- R9: `rdata_o` is all zero whenever `rvalid_o` is 0.
- R10: While `rst_ni` is low, `rvalid_o` is 0. Reset clears the pipeline state but not the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the pipeline state |
| sel_i | input | 1 | Cycle select; 0 is a deselect |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | BYTES*BYTE_W | Write data |
| gw_i | input | 1 | Global write, all bytes |
| bwe_i | input | 1 | Byte-write enable |
| bsel_i | input | BYTES | Per-byte write select |
| pipe_i | input | 1 | Read path: 1 pipelined, 0 flow-through |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Low-power idle with contents retained |
| rdata_o | output | BYTES*BYTE_W | Read data, zero when not valid |
| rvalid_o | output | 1 | Read beat present and driven |

## Verification
A seeded random phase mixes reads, global writes, masked byte writes, deselects, sleep cycles and output-enable drops over a small address window. The small window makes read-after-write collisions frequent. The phase runs once in each read mode, so a latency error shows up as a beat one cycle off. Directed cases cover the rest. Global write with an empty or partial mask separates the global override from a plain mask. An asserted mask with the byte enable low separates a read from a write. A read followed at once by a deselect shows whether the turn-off is single-cycle, and a write during sleep followed by a read at wake-up shows both that the write was blocked and that the core resumes on the first awake cycle.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } rd_mode_e;

  typedef struct packed {
    logic rd;   // captured cycle is a read
    logic act;  // captured cycle is selected and awake
  } stage_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              gw_i,
  input  logic              bwe_i,
  input  logic [BYTES-1:0]  bsel_i,
  input  logic              sleep_i,
  output logic [BYTES-1:0]  wmask_o,
  output logic [ADDR_W-1:0] raddr_o,
  output stage_t            s1_o,
  output logic              rd2_o
);
  logic              live;
  logic              is_wr;
  stage_t            s1_q;
  logic              rd2_q;
  logic [ADDR_W-1:0] addr_q;

  assign live  = sel_i & ~sleep_i;
  assign is_wr = gw_i | bwe_i;

  always_comb begin
    wmask_o = '0;
    if (live) begin
      if (gw_i)       wmask_o = '1;
      else if (bwe_i) wmask_o = bsel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      rd2_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      s1_q.rd  <= live & ~is_wr;
      s1_q.act <= live;
      rd2_q    <= s1_q.rd;
      addr_q   <= addr_i;
    end
  end

  assign raddr_o = addr_q;
  assign s1_o    = s1_q;
  assign rd2_o   = rd2_q;
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int DW    = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [BYTES-1:0]  wmask_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (wmask_i[b])
        mem[waddr_i][b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sram_outpath.sv
module sram_outpath
  import sram_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  rd_mode_e      mode_i,
  input  logic          oe_i,
  input  stage_t        s1_i,
  input  logic          rd2_i,
  input  logic [DW-1:0] arr_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic [DW-1:0] dout_q;
  logic          beat;
  logic [DW-1:0] word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dout_q <= '0;
    else         dout_q <= arr_i;
  end

  // single-cycle deselect: a pipelined beat is cut by the stage-1 deselect
  always_comb begin
    if (mode_i == MODE_PIPE) begin
      beat = rd2_i & s1_i.act;
      word = dout_q;
    end else begin
      beat = s1_i.rd;
      word = arr_i;
    end
  end

  assign rvalid_o = beat & oe_i;
  assign rdata_o  = rvalid_o ? word : '0;
endmodule

// File: rtl/sync_bw_sram.sv
module sync_bw_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8,
  localparam int DW    = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              gw_i,
  input  logic              bwe_i,
  input  logic [BYTES-1:0]  bsel_i,
  input  logic              pipe_i,
  input  logic              oe_i,
  input  logic              sleep_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o
);
  logic [BYTES-1:0]  wmask;
  logic [ADDR_W-1:0] raddr;
  stage_t            s1;
  logic              rd2;
  logic [DW-1:0]     arr_word;
  rd_mode_e          mode;

  assign mode = rd_mode_e'(pipe_i);

  sram_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .addr_i (addr_i),
    .gw_i   (gw_i),
    .bwe_i  (bwe_i),
    .bsel_i (bsel_i),
    .sleep_i(sleep_i),
    .wmask_o(wmask),
    .raddr_o(raddr),
    .s1_o   (s1),
    .rd2_o  (rd2)
  );

  sram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk_i  (clk_i),
    .waddr_i(addr_i),
    .wdata_i(wdata_i),
    .wmask_i(wmask),
    .raddr_i(raddr),
    .rdata_o(arr_word)
  );

  sram_outpath #(.DW(DW)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .oe_i    (oe_i),
    .s1_i    (s1),
    .rd2_i   (rd2),
    .arr_i   (arr_word),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );
endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel_i,
  input logic          gw_i,
  input logic          bwe_i,
  input logic          pipe_i,
  input logic          oe_i,
  input logic          sleep_i,
  input logic [DW-1:0] rdata_o,
  input logic          rvalid_o
);
  logic rd_cyc;
  logic wr_cyc;
  assign rd_cyc = sel_i & ~sleep_i & ~gw_i & ~bwe_i;
  assign wr_cyc = sel_i & ~sleep_i & (gw_i | bwe_i);

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_IDLE: assert (!rvalid_o); // R10
  end

  AST_FLOW_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cyc && !pipe_i) |=> (pipe_i || rvalid_o == oe_i)); // R3
  AST_PIPE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cyc && pipe_i) ##1 (sel_i && !sleep_i && pipe_i) |=> (rvalid_o == oe_i)); // R4
  AST_FLOW_WR_NOBEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cyc && !pipe_i) |=> (pipe_i || !rvalid_o)); // R2
  AST_DESEL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !rvalid_o); // R5
  AST_OE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !rvalid_o); // R6
  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !rvalid_o); // R7
  AST_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0)); // R9
endmodule

bind sync_bw_sram sram_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .gw_i    (gw_i),
  .bwe_i   (bwe_i),
  .pipe_i  (pipe_i),
  .oe_i    (oe_i),
  .sleep_i (sleep_i),
  .rdata_o (rdata_o),
  .rvalid_o(rvalid_o)
);

// File: tb/tb_sync_bw_sram.sv
module tb_sync_bw_sram;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;
  localparam int NWIN = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sel_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          gw_i = 1'b0;
  logic          bwe_i = 1'b0;
  logic [NB-1:0] bsel_i = '0;
  logic          pipe_i = 1'b0;
  logic          oe_i = 1'b1;
  logic          sleep_i = 1'b0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [DW-1:0] m_mem [DEPTH];
  logic          m_rd1 = 1'b0, m_act1 = 1'b0, m_rd2 = 1'b0;
  logic [AW-1:0] m_a1 = '0;
  logic [DW-1:0] m_d2 = '0;

  always #4 clk_i = ~clk_i;

  sync_bw_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) dut (.*);

  function automatic logic exp_valid();
    return oe_i & (pipe_i ? (m_rd2 & m_act1) : m_rd1);
  endfunction

  function automatic logic [DW-1:0] exp_data();
    if (!exp_valid()) return '0;
    return pipe_i ? m_d2 : m_mem[m_a1];
  endfunction

  function automatic logic [NB-1:0] exp_mask(logic s, logic z, logic g, logic b, logic [NB-1:0] bs);
    if (!s || z) return '0;
    if (g) return '1;
    if (b) return bs;
    return '0;
  endfunction

  task automatic check(input string tag);
    logic          ev;
    logic [DW-1:0] ed;
    ev = exp_valid();
    ed = exp_data();
    checks++;
    if (rvalid_o !== ev || rdata_o !== ed) begin
      errors++;
      $display("FAIL %s: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
               tag, rvalid_o, rdata_o, ev, ed);
    end
  endtask

  task automatic model_edge();
    logic [NB-1:0] mk;
    mk = exp_mask(sel_i, sleep_i, gw_i, bwe_i, bsel_i);
    m_d2  = m_mem[m_a1];
    m_rd2 = m_rd1;
    for (int b = 0; b < NB; b++)
      if (mk[b]) m_mem[addr_i][b*BW +: BW] = wdata_i[b*BW +: BW];
    m_rd1  = sel_i & ~sleep_i & ~gw_i & ~bwe_i;
    m_act1 = sel_i & ~sleep_i;
    m_a1   = addr_i;
  endtask

  task automatic step(input logic s, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic g, input logic b, input logic [NB-1:0] bs,
                      input logic p, input logic o, input logic z, input string tag);
    sel_i = s; addr_i = a; wdata_i = d; gw_i = g; bwe_i = b; bsel_i = bs;
    pipe_i = p; oe_i = o; sleep_i = z;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check(tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic p, input string tag);
    step(1'b1, a, '0, 1'b0, 1'b0, '0, p, 1'b1, 1'b0, tag);
  endtask

  task automatic desel(input logic p, input string tag);
    step(1'b0, '0, '0, 1'b0, 1'b0, '0, p, 1'b1, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk_i);
    check("R10");
    @(negedge clk_i);
    check("R10");
    rst_ni = 1'b1;

    // R1: fill window with global writes, read back in flow-through
    for (int i = 0; i < NWIN; i++)
      step(1'b1, AW'(i), $urandom, 1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R1");
    for (int i = 0; i < NWIN; i++) rd(AW'(i), 1'b0, "R1");

    // R2 partial mask, then R8 read right after write
    step(1'b1, 8'd3, 32'hAABBCCDD, 1'b0, 1'b1, 4'b0101, 1'b0, 1'b1, 1'b0, "R2");
    rd(8'd3, 1'b0, "R8");
    // R2: mask without enable is a read, nothing written
    step(1'b1, 8'd4, 32'h12345678, 1'b0, 1'b0, 4'b1111, 1'b0, 1'b1, 1'b0, "R2");
    rd(8'd4, 1'b0, "R2");
    // R1: global write overrides empty and partial masks
    step(1'b1, 8'd5, 32'hDEADBEEF, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, "R1");
    rd(8'd5, 1'b0, "R1");
    step(1'b1, 8'd5, 32'h0F1E2D3C, 1'b1, 1'b1, 4'b0001, 1'b0, 1'b1, 1'b0, "R1");
    rd(8'd5, 1'b0, "R1");

    // R4 pipelined burst latency
    desel(1'b1, "R4");
    rd(8'd6, 1'b1, "R4");
    rd(8'd7, 1'b1, "R4");
    rd(8'd8, 1'b1, "R4");
    rd(8'd9, 1'b1, "R4");
    // R5 deselect cuts pending pipelined beat
    desel(1'b1, "R5");
    desel(1'b1, "R5");
    // R5 flow-through deselect
    rd(8'd9, 1'b0, "R3");
    desel(1'b0, "R5");

    // R6 asynchronous output enable
    rd(8'd9, 1'b0, "R6");
    oe_i = 1'b0; #1; check("R6");
    oe_i = 1'b1; #1; check("R6");
    rd(8'd9, 1'b1, "R6");
    rd(8'd10, 1'b1, "R6");
    oe_i = 1'b0; #1; check("R6");
    oe_i = 1'b1; #1; check("R6");

    // R7 sleep: write blocked, no data, resume on first awake cycle
    step(1'b1, 8'd10, 32'h55555555, 1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b1, "R7");
    step(1'b1, 8'd10, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b1, "R7");
    rd(8'd10, 1'b0, "R7");
    rd(8'd10, 1'b1, "R7");
    step(1'b1, 8'd10, '0, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b1, "R7");
    rd(8'd10, 1'b1, "R7");
    rd(8'd11, 1'b1, "R7");

    // random phase, once per mode
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 600; n++) begin
        logic s, g, b, o, z;
        int r;
        r = $urandom_range(99);
        s = (r < 85);
        g = ($urandom_range(99) < 15);
        b = ($urandom_range(99) < 25);
        o = ($urandom_range(99) < 90);
        z = ($urandom_range(99) < 5);
        step(s, AW'($urandom_range(NWIN-1)), $urandom, g, b, NB'($urandom),
             m[0], o, z, m[0] ? "R4" : "R3");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule